// File: doc/BRIEF.md
# Two-Way Byte Mailbox Between a Host Bus and an APB Slave

The block moves short messages between an external processor on an 8-bit register-window bus and an internal processor on an APB slave port. There is one byte buffer in each direction. The host-to-processor direction is called inbound and the processor-to-host direction is called outbound. Each direction also has a one-bit status flag, and that flag drives an interrupt line to the side that receives the message.

On the host side, each buffer is reached through a single data address. Behind that address sits an index counter that steps by one on every access and wraps at the buffer depth. A write of any value to a companion index address sets that counter back to zero. On the APB side there is no index: every byte of both buffers has its own address.

The sender fills a buffer and then sets the status flag, which raises the interrupt. The receiver reads the message and then clears the flag, which drops the interrupt. Both ports run on one clock.

Top module: `mbox_bridge`

## Requirements
- R1: Host address decode. 000 is the outbound status, 001 the outbound index, 011 the inbound status, 100 the inbound index, 110 the outbound data port and 111 the inbound data port. Status reads return the flag in bit 0 with the other bits zero. Index reads return the index value. Host reads of 010 and 101 return zero, and host writes to 010, 101 and 110 change nothing.
- R2: A host write of any value to 100 sets the inbound index to zero. A host write of any value to 001 sets the outbound index to zero.
- R3: A host write to 111 stores the byte at the inbound index and then adds one to the index. The index wraps from DEPTH-1 (31 by default) to 0.
- R4: A host read of 110 captures the outbound byte at the outbound index and then adds one to that index, with the same wrap as R3. Host read data is registered at the accepted strobe edge and holds its value until the next accepted read.
- R5: A host write to 011 loads the inbound status from data bit 0. A value of 01 sets the flag and raises h2c_irq, and a value of 00 clears it.
- R6: An APB write to the inbound status with pwdata bit 0 set clears the flag and drops h2c_irq. With bit 0 clear, the write has no effect. If a host write to 011 lands in the same cycle, the host write wins.
- R7: An APB write to the outbound status loads the flag from pwdata bit 0, so 1 raises c2h_irq and 0 clears it. A host write of any value to 000 clears the flag. If both land in the same cycle, the APB write wins.
- R8: APB map, with paddr[6:5] selecting the region and paddr[4:0] the byte. Region 00 is the inbound buffer: it can be read, and writes to it are ignored. Region 01 is the outbound buffer: it can be read and written. Region 10 holds the status flags: paddr[0]=0 is the inbound status and 1 is the outbound status, with the flag in prdata bit 0. Region 11 reads zero. prdata[15:8] is always zero. An access happens only when psel and penable are both high.
- R9: A host access happens at the first clock edge where hcs_n and has_n are both low. Holding the strobe for more cycles adds no further access. The strobe must go high before the next access.
- R10: hdout_oe is high exactly while hcs_n is low and hrw is high (a read).
- R11: After reset, both status flags and both indices are zero and both interrupt lines are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared clock |
| rst_n | input | 1 | Active-low reset |
| psel | input | 1 | APB slave select |
| penable | input | 1 | APB enable phase |
| pwrite | input | 1 | APB direction, 1 = write |
| paddr | input | 7 | APB byte address |
| pwdata | input | 8 | APB write data |
| prdata | output | 16 | APB read data |
| h2c_irq | output | 1 | Interrupt to the internal processor |
| hcs_n | input | 1 | Host chip select, active low |
| has_n | input | 1 | Host address strobe, active low |
| hrw | input | 1 | Host direction, 1 = read |
| haddr | input | 3 | Host register address |
| hdin | input | 8 | Host write data |
| hdout | output | 8 | Host read data |
| hdout_oe | output | 1 | Host data output enable |
| c2h_irq | output | 1 | Interrupt to the host |

## Verification
The bench writes 33 bytes through the inbound port. A design with a missing or badly wrapped index would fail to overwrite byte 0 or would report the wrong index. The bench holds a strobe low for several cycles; a design that takes one access per cycle would advance the index more than once. It also makes the host and the APB touch the same status flag in the same cycle, where the wrong priority would lose a fresh message or keep a stale interrupt. Finally, it writes to the inbound buffer from APB, writes 0 to clear the inbound status from APB, and writes to the outbound data port from the host, then reads back to show that none of these changed anything.

// File: rtl/mbox_pkg.sv
package mbox_pkg;

    typedef enum logic [2:0] {
        HR_OSTAT = 3'b000,
        HR_OIDX  = 3'b001,
        HR_RSV2  = 3'b010,
        HR_ISTAT = 3'b011,
        HR_IIDX  = 3'b100,
        HR_RSV5  = 3'b101,
        HR_OBUF  = 3'b110,
        HR_IBUF  = 3'b111
    } host_reg_e;

    typedef enum logic [1:0] {
        AR_INBUF  = 2'b00,
        AR_OUTBUF = 2'b01,
        AR_STAT   = 2'b10,
        AR_NONE   = 2'b11
    } apb_region_e;

    typedef struct packed {
        logic      vld;
        logic      rd;
        host_reg_e sel;
        logic [7:0] wdata;
    } host_req_t;

endpackage

// File: rtl/mbox_host_port.sv
module mbox_host_port
    import mbox_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hcs_n,
    input  logic       has_n,
    input  logic       hrw,
    input  logic [2:0] haddr,
    input  logic [7:0] hdin,
    output host_req_t  req,
    output logic       hdout_oe
);

    typedef struct packed {
        logic held;
    } hst_t;

    hst_t st_d, st_q;
    logic strobe;

    always_comb begin
        strobe     = !hcs_n && !has_n;
        st_d       = st_q;
        st_d.held  = strobe;
        req.vld    = strobe && !st_q.held;
        req.rd     = hrw;
        req.sel    = host_reg_e'(haddr);
        req.wdata  = hdin;
        hdout_oe   = !hcs_n && hrw;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    // R9: a held strobe yields only one access
    a_r9_single_access: assert property (@(posedge clk) disable iff (!rst_n)
        req.vld |=> !req.vld);

endmodule

// File: rtl/mbox_apb_port.sv
module mbox_apb_port
    import mbox_pkg::*;
#(
    parameter int IDX_W = 5
) (
    input  logic             psel,
    input  logic             penable,
    input  logic             pwrite,
    input  logic [IDX_W+1:0] paddr,
    output logic             wr_en,
    output apb_region_e      region,
    output logic [IDX_W-1:0] offset
);

    always_comb begin
        wr_en  = psel && penable && pwrite;
        region = apb_region_e'(paddr[IDX_W+1:IDX_W]);
        offset = paddr[IDX_W-1:0];
    end

endmodule

// File: rtl/mbox_store.sv
module mbox_store
    import mbox_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  host_req_t                hreq,
    input  logic                     apb_wr,
    input  apb_region_e              apb_region,
    input  logic [$clog2(DEPTH)-1:0] apb_off,
    input  logic [7:0]               apb_wdata,
    output logic [15:0]              prdata,
    output logic [7:0]               hdout,
    output logic                     h2c_irq,
    output logic                     c2h_irq
);

    localparam int IDX_W = $clog2(DEPTH);
    typedef logic [IDX_W-1:0] idx_t;

    typedef struct packed {
        logic [DEPTH-1:0][7:0] ibuf;
        logic [DEPTH-1:0][7:0] obuf;
        idx_t                  iidx;
        idx_t                  oidx;
        logic                  istat;
        logic                  ostat;
        logic [7:0]            hrd;
    } st_t;

    st_t st_d, st_q;
    logic host_wr, host_rd;
    logic apb_istat_clr, apb_ostat_wr;
    logic [7:0] host_view;

    always_comb begin
        host_wr       = hreq.vld && !hreq.rd;
        host_rd       = hreq.vld &&  hreq.rd;
        apb_istat_clr = apb_wr && apb_region == AR_STAT && !apb_off[0] && apb_wdata[0];
        apb_ostat_wr  = apb_wr && apb_region == AR_STAT &&  apb_off[0];

        case (hreq.sel)
            HR_OSTAT: host_view = {7'd0, st_q.ostat};
            HR_OIDX:  host_view = 8'(st_q.oidx);
            HR_ISTAT: host_view = {7'd0, st_q.istat};
            HR_IIDX:  host_view = 8'(st_q.iidx);
            HR_OBUF:  host_view = st_q.obuf[st_q.oidx];
            HR_IBUF:  host_view = st_q.ibuf[st_q.iidx];
            default:  host_view = 8'd0;
        endcase

        st_d = st_q;

        // processor clears inbound flag first; a host write in the same cycle overrides
        if (apb_istat_clr) st_d.istat = 1'b0;

        if (host_wr) begin
            case (hreq.sel)
                HR_OSTAT: st_d.ostat = 1'b0;
                HR_OIDX:  st_d.oidx  = '0;
                HR_ISTAT: st_d.istat = hreq.wdata[0];
                HR_IIDX:  st_d.iidx  = '0;
                HR_IBUF: begin
                    st_d.ibuf[st_q.iidx] = hreq.wdata;
                    st_d.iidx            = st_q.iidx + idx_t'(1);
                end
                default: ;
            endcase
        end

        if (host_rd) begin
            st_d.hrd = host_view;
            if (hreq.sel == HR_OBUF) st_d.oidx = st_q.oidx + idx_t'(1);
        end

        // processor write to outbound flag applied last so it wins over a host clear
        if (apb_ostat_wr) st_d.ostat = apb_wdata[0];
        if (apb_wr && apb_region == AR_OUTBUF) st_d.obuf[apb_off] = apb_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        case (apb_region)
            AR_INBUF:  prdata = {8'd0, st_q.ibuf[apb_off]};
            AR_OUTBUF: prdata = {8'd0, st_q.obuf[apb_off]};
            AR_STAT:   prdata = {15'd0, apb_off[0] ? st_q.ostat : st_q.istat};
            default:   prdata = 16'd0;
        endcase
        hdout   = st_q.hrd;
        h2c_irq = st_q.istat;
        c2h_irq = st_q.ostat;
    end

    // R2: index clear
    a_r2_iidx_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && hreq.sel == HR_IIDX) |=> (st_q.iidx == '0));
    // R3: inbound index steps and wraps
    a_r3_iidx_step: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && hreq.sel == HR_IBUF) |=> (st_q.iidx == idx_t'($past(st_q.iidx) + 1)));
    // R4: outbound index steps on data-port read
    a_r4_oidx_step: assert property (@(posedge clk) disable iff (!rst_n)
        (host_rd && hreq.sel == HR_OBUF) |=> (st_q.oidx == idx_t'($past(st_q.oidx) + 1)));
    // R5: host set raises processor interrupt
    a_r5_h2c_set: assert property (@(posedge clk) disable iff (!rst_n)
        (host_wr && hreq.sel == HR_ISTAT && hreq.wdata[0]) |=> h2c_irq);
    // R7: processor write decides the outbound interrupt
    a_r7_c2h_cpu: assert property (@(posedge clk) disable iff (!rst_n)
        apb_ostat_wr |=> (c2h_irq == $past(apb_wdata[0])));
    // R6: inbound flag changes only on its own writers
    a_r6_istat_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!apb_istat_clr && !(host_wr && hreq.sel == HR_ISTAT)) |=> $stable(h2c_irq));

endmodule

// File: rtl/mbox_bridge.sv
module mbox_bridge
    import mbox_pkg::*;
#(
    parameter int DEPTH = 32
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     psel,
    input  logic                     penable,
    input  logic                     pwrite,
    input  logic [$clog2(DEPTH)+1:0] paddr,
    input  logic [7:0]               pwdata,
    output logic [15:0]              prdata,
    output logic                     h2c_irq,
    input  logic                     hcs_n,
    input  logic                     has_n,
    input  logic                     hrw,
    input  logic [2:0]               haddr,
    input  logic [7:0]               hdin,
    output logic [7:0]               hdout,
    output logic                     hdout_oe,
    output logic                     c2h_irq
);

    localparam int IDX_W = $clog2(DEPTH);

    host_req_t          hreq;
    logic               apb_wr;
    apb_region_e        apb_region;
    logic [IDX_W-1:0]   apb_off;

    mbox_host_port u_host (
        .clk      (clk),
        .rst_n    (rst_n),
        .hcs_n    (hcs_n),
        .has_n    (has_n),
        .hrw      (hrw),
        .haddr    (haddr),
        .hdin     (hdin),
        .req      (hreq),
        .hdout_oe (hdout_oe)
    );

    mbox_apb_port #(.IDX_W(IDX_W)) u_apb (
        .psel    (psel),
        .penable (penable),
        .pwrite  (pwrite),
        .paddr   (paddr),
        .wr_en   (apb_wr),
        .region  (apb_region),
        .offset  (apb_off)
    );

    mbox_store #(.DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .hreq       (hreq),
        .apb_wr     (apb_wr),
        .apb_region (apb_region),
        .apb_off    (apb_off),
        .apb_wdata  (pwdata),
        .prdata     (prdata),
        .hdout      (hdout),
        .h2c_irq    (h2c_irq),
        .c2h_irq    (c2h_irq)
    );

endmodule

// File: tb/mbox_bridge_bench.sv
module mbox_bridge_bench;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [6:0] paddr = '0;
    logic [7:0] pwdata = '0;
    logic [15:0] prdata;
    logic h2c_irq, c2h_irq;
    logic hcs_n = 1'b1, has_n = 1'b1, hrw = 1'b0;
    logic [2:0] haddr = '0;
    logic [7:0] hdin = '0;
    logic [7:0] hdout;
    logic hdout_oe;

    int n_vec = 0;
    int n_bad = 0;

    logic [7:0] m_ibuf [32];
    logic [7:0] m_obuf [32];
    logic [4:0] m_iidx, m_oidx;
    logic m_istat, m_ostat;

    always #2.5 clk = ~clk;

    mbox_bridge u_mbox_bridge (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .h2c_irq(h2c_irq),
        .hcs_n(hcs_n), .has_n(has_n), .hrw(hrw), .haddr(haddr), .hdin(hdin),
        .hdout(hdout), .hdout_oe(hdout_oe), .c2h_irq(c2h_irq)
    );

    task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] host_view(input logic [2:0] a);
        case (a)
            3'd0: return {7'd0, m_ostat};
            3'd1: return {3'd0, m_oidx};
            3'd3: return {7'd0, m_istat};
            3'd4: return {3'd0, m_iidx};
            3'd6: return m_obuf[m_oidx];
            3'd7: return m_ibuf[m_iidx];
            default: return 8'd0;
        endcase
    endfunction

    function automatic logic [15:0] apb_view(input logic [6:0] a);
        case (a[6:5])
            2'd0: return {8'd0, m_ibuf[a[4:0]]};
            2'd1: return {8'd0, m_obuf[a[4:0]]};
            2'd2: return {15'd0, a[0] ? m_ostat : m_istat};
            default: return 16'd0;
        endcase
    endfunction

    task automatic model_host_wr(input logic [2:0] a, input logic [7:0] d);
        case (a)
            3'd0: m_ostat = 1'b0;
            3'd1: m_oidx = '0;
            3'd3: m_istat = d[0];
            3'd4: m_iidx = '0;
            3'd7: begin m_ibuf[m_iidx] = d; m_iidx = m_iidx + 5'd1; end
            default: ;
        endcase
    endtask

    task automatic model_apb_wr(input logic [6:0] a, input logic [7:0] d);
        if (a[6:5] == 2'd1) m_obuf[a[4:0]] = d;
        else if (a[6:5] == 2'd2) begin
            if (a[0]) m_ostat = d[0];
            else if (d[0]) m_istat = 1'b0;
        end
    endtask

    task automatic chk_irq(input string req);
        chk({req, " h2c_irq"}, {15'd0, h2c_irq}, {15'd0, m_istat});
        chk({req, " c2h_irq"}, {15'd0, c2h_irq}, {15'd0, m_ostat});
    endtask

    task automatic host_wr(input logic [2:0] a, input logic [7:0] d, input int hold, input string req);
        @(negedge clk);
        hcs_n = 1'b0; has_n = 1'b0; hrw = 1'b0; haddr = a; hdin = d;
        for (int i = 0; i < hold; i++) @(negedge clk);
        chk({req, " R10 oe low on write"}, {15'd0, hdout_oe}, 16'd0);
        hcs_n = 1'b1; has_n = 1'b1;
        model_host_wr(a, d);
        @(negedge clk);
    endtask

    task automatic host_rd(input logic [2:0] a, input int hold, input string req);
        logic [7:0] exp;
        @(negedge clk);
        hcs_n = 1'b0; has_n = 1'b0; hrw = 1'b1; haddr = a;
        exp = host_view(a);
        if (a == 3'd6) m_oidx = m_oidx + 5'd1;
        for (int i = 0; i < hold; i++) @(negedge clk);
        chk({req, " host read"}, {8'd0, hdout}, {8'd0, exp});
        chk({req, " R10 oe high on read"}, {15'd0, hdout_oe}, 16'd1);
        hcs_n = 1'b1; has_n = 1'b1; hrw = 1'b0;
        @(negedge clk);
    endtask

    task automatic apb_wr(input logic [6:0] a, input logic [7:0] d);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = a; pwdata = d; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
        model_apb_wr(a, d);
    endtask

    task automatic apb_rd(input logic [6:0] a, input string req);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b0; paddr = a; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        #1;
        chk({req, " apb read"}, prdata, apb_view(a));
        @(negedge clk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic both_wr(input logic [2:0] ha, input logic [7:0] hd, input logic [6:0] pa, input logic [7:0] pd);
        @(negedge clk);
        psel = 1'b1; pwrite = 1'b1; paddr = pa; pwdata = pd; penable = 1'b0;
        @(negedge clk);
        penable = 1'b1;
        hcs_n = 1'b0; has_n = 1'b0; hrw = 1'b0; haddr = ha; hdin = hd;
        @(negedge clk);
        psel = 1'b0; penable = 1'b0; hcs_n = 1'b1; has_n = 1'b1;
        model_apb_wr(pa, pd);
        model_host_wr(ha, hd);
        if (pa[6:5] == 2'd2 && pa[0]) model_apb_wr(pa, pd);
        @(negedge clk);
    endtask

    initial begin
        #(5.0 * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        void'($urandom(32'd5151));
        for (int i = 0; i < 32; i++) begin m_ibuf[i] = '0; m_obuf[i] = '0; end
        m_iidx = '0; m_oidx = '0; m_istat = 1'b0; m_ostat = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R11 reset state
        chk_irq("R11");
        chk("R10 oe idle", {15'd0, hdout_oe}, 16'd0);
        host_rd(3'd0, 1, "R11 ostat");
        host_rd(3'd1, 1, "R11 oidx");
        host_rd(3'd3, 1, "R11 istat");
        host_rd(3'd4, 1, "R11 iidx");

        // R3 fill past the end, wrap overwrites byte 0
        for (int i = 0; i < 33; i++) host_wr(3'd7, 8'(8'hA0 + i), 1, "R3");
        host_rd(3'd4, 1, "R3 wrap index");
        apb_rd(7'h00, "R3 byte0 overwritten");
        apb_rd(7'h1F, "R3 last byte");

        // R9 long strobe gives one step
        host_wr(3'd7, 8'h5C, 4, "R9");
        host_rd(3'd4, 1, "R9 index one step");
        host_rd(3'd7, 3, "R9 inbound window read");

        // R2 index clears
        host_wr(3'd4, 8'hFF, 1, "R2");
        host_rd(3'd4, 1, "R2 iidx zero");

        // R5/R6 inbound flag
        host_wr(3'd3, 8'h01, 1, "R5"); chk_irq("R5 set");
        apb_rd(7'h40, "R8 istat");
        apb_wr(7'h40, 8'h00); chk_irq("R6 write 0 no effect");
        apb_wr(7'h40, 8'h01); chk_irq("R6 clear");
        host_wr(3'd3, 8'h01, 1, "R5"); host_wr(3'd3, 8'h00, 1, "R5"); chk_irq("R5 host clear");

        // R8 writes to inbound region ignored, outbound written directly
        apb_wr(7'h03, 8'h77); apb_rd(7'h03, "R8 inbound write ignored");
        for (int i = 0; i < 32; i++) apb_wr(7'(7'h20 + i), 8'(8'h30 + 3 * i));
        apb_rd(7'h60, "R8 reserved region");

        // R7 outbound flag, R4 streaming read with wrap
        apb_wr(7'h41, 8'h01); chk_irq("R7 set");
        host_wr(3'd1, 8'h5A, 1, "R2");
        for (int i = 0; i < 34; i++) host_rd(3'd6, 1 + (i % 3), "R4");
        host_rd(3'd1, 1, "R4 oidx wrap");
        host_wr(3'd6, 8'hEE, 1, "R1"); apb_rd(7'h22, "R1 write to 110 ignored");
        host_rd(3'd1, 1, "R1 oidx unchanged");
        host_rd(3'd2, 1, "R1 reserved 010"); host_rd(3'd5, 1, "R1 reserved 101");
        host_wr(3'd0, 8'h3C, 1, "R7"); chk_irq("R7 host clear");
        apb_wr(7'h41, 8'h01); apb_wr(7'h41, 8'h00); chk_irq("R7 cpu clear");

        // same-cycle priority
        both_wr(3'd3, 8'h01, 7'h40, 8'h01); chk_irq("R6 host wins");
        both_wr(3'd0, 8'h00, 7'h41, 8'h01); chk_irq("R7 cpu wins");

        // random mix
        for (int n = 0; n < 600; n++) begin
            int op;
            logic [2:0] ha;
            logic [6:0] pa;
            logic [7:0] d;
            op = int'($urandom_range(0, 5));
            ha = 3'($urandom_range(0, 7));
            pa = 7'($urandom_range(0, 127));
            d  = 8'($urandom);
            case (op)
                0, 1: host_wr((op == 0) ? 3'd7 : ha, d, 1 + int'($urandom_range(0, 2)), "R3 rand");
                2:    host_rd(ha, 1 + int'($urandom_range(0, 2)), "R4 rand");
                3:    apb_wr(pa, d);
                4:    apb_rd(pa, "R8 rand");
                default: apb_wr({2'd2, 4'd0, pa[0]}, d);
            endcase
            chk_irq("R6 R7 rand");
        end

        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule